// File: doc/BRIEF.md
# Instruction Fetch Unit with Compressed-Instruction Assembly

The block turns a fetch address into instruction bits. In front of address translation and memory sits a small direct-mapped fetch buffer holding whole instructions. A word-aligned fetch that finds its address in the buffer is answered one cycle later and makes no outside request. A fetch that misses goes out through two simple request ports. The translation port maps a virtual address to a physical one or reports a fault. The memory port reads a word or a halfword at a physical address.

When compressed instructions are enabled, a fetch may start at a halfword offset. The block translates and reads the low halfword first. When that halfword is itself a complete 16-bit instruction, the fetch ends there. Otherwise the address plus 2 is translated on its own and its halfword supplies the upper half of the instruction. Every successful fetch writes its address, with bit 0 set, into the buffer entry as the tag, and writes the instruction into the data. A fetch at a halfword offset therefore replaces the entry of the aligned word it shares an index with, yet can never hit itself.

The translation logic and the instruction decode lie outside this block. A flush input invalidates the whole buffer.

Top module: `cfetch_unit`

## Requirements
- R1: After reset, busy, rspValid, xlReq and memReq are low and every buffer entry is invalid, so the first fetch of any address misses.
- R2: A word-aligned fetch that misses issues one translation of the fetch address, then one word read (memHalf=0) at the returned physical address. The response carries that word with rspCause 0. xlReq and xlVaddr stay steady until xlAck.
- R3: A fetch whose address has bits 1:0 = 00 and whose buffer tag equals the address OR 1 is a hit. It answers in the next cycle with the stored instruction and makes no translation or memory request.
- R4: The buffer index is address bits 6:2 (ENTRIES=32) and the tag is the full address. Two aligned addresses 128 bytes apart share an entry, and each fill evicts the other.
- R5: With compEn=1 and address bits 1:0 = 10, the block translates the address and reads a halfword (memHalf=1, data in memData[15:0]). If that halfword's bits 1:0 are not 11, the response is {16'h0000, halfword}, with no second translation.
- R6: If that low halfword has bits 1:0 = 11, the block translates address+2 separately, reads that halfword and responds with {upper halfword, lower halfword}.
- R7: A fetch whose address bits 1:0 are nonzero, and which is not (bits 1:0 = 10 with compEn=1), responds next cycle with rspCause 1 (address misaligned) and rspInsn 0. It makes no outside request.
- R8: A fault on either translation ends the fetch with rspCause 2 (access fault) and rspInsn 0. No memory read follows the faulting translation, and the buffer is left unchanged.
- R9: A successful fetch writes tag = address OR 1 into entry address bits 6:2. A halfword-offset fetch therefore never hits, and it evicts the aligned word at that index.
- R10: A flush pulse clears every tag to zero. Later fetches miss until they are refilled.
- R11: While busy is high, fetchValid is ignored: it produces no response and no outside request.
- R12: Each accepted fetch produces exactly one single-cycle rspValid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all buffer entries |
| fetchValid | input | 1 | Fetch request, taken when busy is low |
| fetchAddr | input | AW | Virtual fetch address |
| compEn | input | 1 | Enable 16-bit compressed instructions |
| busy | output | 1 | A miss is in progress |
| rspValid | output | 1 | Response pulse |
| rspInsn | output | 32 | Fetched instruction (0 on exception) |
| rspCause | output | 2 | 0 none, 1 misaligned, 2 access fault |
| xlReq | output | 1 | Translation request |
| xlVaddr | output | AW | Address to translate |
| xlAck | input | 1 | Translation result valid |
| xlFault | input | 1 | Translation fault |
| xlPaddr | input | AW | Translated address |
| memReq | output | 1 | Memory read request |
| memAddr | output | AW | Physical read address |
| memHalf | output | 1 | 1 = halfword read, 0 = word read |
| memAck | input | 1 | Read data valid |
| memData | input | 32 | Read data (halfword in bits 15:0) |

## Verification
The bench builds the unit with its default values: 32 buffer entries and a 32-bit address. With 32 entries, two aligned addresses 128 bytes apart collide on one index, so eviction between neighbours and the halfword-offset fill that displaces an aligned word can both be reached with a few fetches. The full 32-bit address lets a halfword fetch at the last halfword of one translation region cross into a faulting region, so a fault on the second, separate translation can be tested.

// File: rtl/cfetch_pkg.sv
package cfetch_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_XLO,
    S_RDLO,
    S_XHI,
    S_RDHI
  } fstate_t;

  typedef enum logic [1:0] {
    C_NONE     = 2'd0,
    C_MISALIGN = 2'd1,
    C_ACCESS   = 2'd2
  } fcause_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic    latch;     // capture request address
    logic    selHi;     // second-halfword phase
    logic    capPaddr;  // capture translated address
    logic    capLo;     // hold low halfword for assembly
    logic    fill;      // write buffer entry
    logic    rspEn;     // issue response
    logic    rspHit;    // response data from buffer
    fcause_t rspCause;
  } fstrobe_t;

endpackage

// File: rtl/cfetch_ctrl.sv
module cfetch_ctrl
  import cfetch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchValid,
  input  logic [1:0] fetchAddrLo,
  input  logic       compEn,
  input  logic       hit,
  input  logic       reqHalf,
  input  logic       loIsComp,
  input  logic       xlAck,
  input  logic       xlFault,
  input  logic       memAck,
  output fstrobe_t   stb,
  output logic       busy,
  output logic       xlReq,
  output logic       memReq
);

  fstate_t state, nextState;

  logic aligned, halfOk;
  assign aligned = (fetchAddrLo == 2'b00);
  assign halfOk  = (fetchAddrLo == 2'b10) && compEn;

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (fetchValid) begin
          if (aligned && hit) begin
            stb.rspEn  = 1'b1;
            stb.rspHit = 1'b1;
          end else if (aligned || halfOk) begin
            stb.latch = 1'b1;
            nextState = S_XLO;
          end else begin
            stb.rspEn    = 1'b1;
            stb.rspCause = C_MISALIGN;
          end
        end
      end
      S_XLO: begin
        if (xlAck) begin
          if (xlFault) begin
            stb.rspEn    = 1'b1;
            stb.rspCause = C_ACCESS;
            nextState    = S_IDLE;
          end else begin
            stb.capPaddr = 1'b1;
            nextState    = S_RDLO;
          end
        end
      end
      S_RDLO: begin
        if (memAck) begin
          if (reqHalf && !loIsComp) begin
            stb.capLo = 1'b1;
            nextState = S_XHI;
          end else begin
            stb.fill  = 1'b1;
            stb.rspEn = 1'b1;
            nextState = S_IDLE;
          end
        end
      end
      S_XHI: begin
        stb.selHi = 1'b1;
        if (xlAck) begin
          if (xlFault) begin
            stb.rspEn    = 1'b1;
            stb.rspCause = C_ACCESS;
            nextState    = S_IDLE;
          end else begin
            stb.capPaddr = 1'b1;
            nextState    = S_RDHI;
          end
        end
      end
      S_RDHI: begin
        stb.selHi = 1'b1;
        if (memAck) begin
          stb.fill  = 1'b1;
          stb.rspEn = 1'b1;
          nextState = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign busy   = (state != S_IDLE);
  assign xlReq  = (state == S_XLO) || (state == S_XHI);
  assign memReq = (state == S_RDLO) || (state == S_RDHI);

  // R2: a pending translation request is held until acknowledged
  p_xl_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    xlReq && !xlAck |=> xlReq);

  // R11: new requests do not disturb a miss in progress
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy && fetchValid && !xlAck && !memAck |=> state == $past(state));

endmodule

// File: rtl/cfetch_dpath.sv
module cfetch_dpath
  import cfetch_pkg::*;
#(
  parameter int AW      = 32,
  parameter int ENTRIES = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  fstrobe_t      stb,
  input  logic [AW-1:0] fetchAddr,
  output logic          hit,
  output logic          reqHalf,
  output logic          loIsComp,
  output logic [AW-1:0] xlVaddr,
  input  logic [AW-1:0] xlPaddr,
  output logic [AW-1:0] memAddr,
  input  logic [31:0]   memData,
  output logic          rspValid,
  output logic [31:0]   rspInsn,
  output logic [1:0]    rspCause
);

  localparam int IDXW = $clog2(ENTRIES);
  localparam logic [AW-1:0] VBIT = AW'(1);
  localparam logic [AW-1:0] HSTEP = AW'(2);

  logic [AW-1:0] tagMem [ENTRIES];
  logic [31:0]   dataMem[ENTRIES];
  logic [AW-1:0] reqAddr, paddrReg;
  logic [15:0]   loReg;
  logic [31:0]   fillData;
  logic [IDXW-1:0] fIdx, rIdx;

  assign fIdx     = fetchAddr[IDXW+1:2];
  assign rIdx     = reqAddr[IDXW+1:2];
  assign hit      = (tagMem[fIdx] == (fetchAddr | VBIT));
  assign reqHalf  = reqAddr[1];
  assign loIsComp = (memData[1:0] != 2'b11);
  assign xlVaddr  = stb.selHi ? (reqAddr + HSTEP) : reqAddr;
  assign memAddr  = paddrReg;

  always_comb begin
    if (stb.selHi)    fillData = {memData[15:0], loReg};
    else if (reqHalf) fillData = {16'h0000, memData[15:0]};
    else              fillData = memData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr  <= '0;
      paddrReg <= '0;
      loReg    <= '0;
    end else begin
      if (stb.latch)    reqAddr  <= fetchAddr;
      if (stb.capPaddr) paddrReg <= xlPaddr;
      if (stb.capLo)    loReg    <= memData[15:0];
    end
  end

  // Tags: bit 0 doubles as valid; flush wins over a fill
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) tagMem[i] <= '0;
    end else if (flush) begin
      for (int i = 0; i < ENTRIES; i++) tagMem[i] <= '0;
    end else if (stb.fill) begin
      tagMem[rIdx] <= reqAddr | VBIT;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.fill) dataMem[rIdx] <= fillData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspInsn  <= '0;
      rspCause <= '0;
    end else begin
      rspValid <= stb.rspEn;
      if (stb.rspEn) begin
        rspCause <= stb.rspCause;
        if (stb.rspHit)                 rspInsn <= dataMem[fIdx];
        else if (stb.rspCause != C_NONE) rspInsn <= '0;
        else                            rspInsn <= fillData;
      end
    end
  end

  // R10: after a flush the entry under any fetch address is invalid
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !tagMem[fIdx][0]);

endmodule

// File: rtl/cfetch_unit.sv
module cfetch_unit
  import cfetch_pkg::*;
#(
  parameter int AW      = 32,
  parameter int ENTRIES = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          fetchValid,
  input  logic [AW-1:0] fetchAddr,
  input  logic          compEn,
  output logic          busy,
  output logic          rspValid,
  output logic [31:0]   rspInsn,
  output logic [1:0]    rspCause,
  output logic          xlReq,
  output logic [AW-1:0] xlVaddr,
  input  logic          xlAck,
  input  logic          xlFault,
  input  logic [AW-1:0] xlPaddr,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  output logic          memHalf,
  input  logic          memAck,
  input  logic [31:0]   memData
);

  fstrobe_t stb;
  logic hitW, reqHalfW, loIsCompW;

  cfetch_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchValid (fetchValid),
    .fetchAddrLo(fetchAddr[1:0]),
    .compEn     (compEn),
    .hit        (hitW),
    .reqHalf    (reqHalfW),
    .loIsComp   (loIsCompW),
    .xlAck      (xlAck),
    .xlFault    (xlFault),
    .memAck     (memAck),
    .stb        (stb),
    .busy       (busy),
    .xlReq      (xlReq),
    .memReq     (memReq)
  );

  cfetch_dpath #(.AW(AW), .ENTRIES(ENTRIES)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .stb      (stb),
    .fetchAddr(fetchAddr),
    .hit      (hitW),
    .reqHalf  (reqHalfW),
    .loIsComp (loIsCompW),
    .xlVaddr  (xlVaddr),
    .xlPaddr  (xlPaddr),
    .memAddr  (memAddr),
    .memData  (memData),
    .rspValid (rspValid),
    .rspInsn  (rspInsn),
    .rspCause (rspCause)
  );

  assign memHalf = reqHalfW;

  // R2: the translated address is steady while waiting
  p_vaddr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    xlReq && !xlAck |=> $stable(xlVaddr));

  // R3: a hit answers next cycle, clean, and stays idle
  p_hit_fast_r3: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && !busy && fetchAddr[1:0] == 2'b00 && hitW
    |=> rspValid && rspCause == 2'd0 && !busy && !xlReq);

  // R7: misaligned fetch raises cause 1 without outside traffic
  p_misalign_r7: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && !busy && fetchAddr[1:0] != 2'b00 &&
    !(fetchAddr[1:0] == 2'b10 && compEn)
    |=> rspValid && rspCause == 2'd1 && !xlReq && !memReq);

  // R8: a translation fault aborts with cause 2 and no memory read
  p_fault_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    xlReq && xlAck && xlFault |=> rspValid && rspCause == 2'd2 && !memReq && !busy);

  // R5: a compressed low halfword completes the fetch
  p_comp_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && memHalf && !stb.selHi && loIsCompW |=> rspValid && !busy);

endmodule

// File: tb/cfetch_unit_tb_top.sv
module cfetch_unit_tb_top;

  localparam int AW = 32;

  typedef struct packed {
    logic [31:0] addr;
    logic        comp;
    logic [1:0]  cause;
    logic [1:0]  nXl;
    logic [1:0]  nMem;
    logic        fast;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC[NV] = '{
    '{32'h0000_1000, 1'b0, 2'd0, 2'd1, 2'd1, 1'b0}, // R1/R2 first fetch misses
    '{32'h0000_1000, 1'b0, 2'd0, 2'd0, 2'd0, 1'b1}, // R3 hit
    '{32'h0000_2002, 1'b1, 2'd0, 2'd1, 2'd1, 1'b0}, // R5 compressed
    '{32'h0000_2032, 1'b1, 2'd0, 2'd2, 2'd2, 1'b0}, // R6 assembled
    '{32'h0000_2032, 1'b1, 2'd0, 2'd2, 2'd2, 1'b0}, // R9 halfword never hits
    '{32'h0000_2002, 1'b0, 2'd1, 2'd0, 2'd0, 1'b1}, // R7 compEn off
    '{32'h0000_1001, 1'b1, 2'd1, 2'd0, 2'd0, 1'b1}, // R7 odd
    '{32'h0000_1003, 1'b1, 2'd1, 2'd0, 2'd0, 1'b1}, // R7 offset 3
    '{32'hF000_0100, 1'b0, 2'd2, 2'd1, 2'd0, 1'b0}, // R8 first fault
    '{32'hEFFF_FFFE, 1'b1, 2'd2, 2'd2, 2'd1, 1'b0}, // R8 second fault
    '{32'h0000_1080, 1'b0, 2'd0, 2'd1, 2'd1, 1'b0}, // R4 alias evicts
    '{32'h0000_1000, 1'b0, 2'd0, 2'd1, 2'd1, 1'b0}, // R4 miss after evict
    '{32'h0000_1000, 1'b0, 2'd0, 2'd0, 2'd0, 1'b1}, // R3 hit again
    '{32'h0000_1002, 1'b1, 2'd0, 2'd1, 2'd1, 1'b0}, // R9 halfword fill
    '{32'h0000_1000, 1'b0, 2'd0, 2'd1, 2'd1, 1'b0}, // R9 evicted by halfword
    '{32'hF000_0000, 1'b0, 2'd2, 2'd1, 2'd0, 1'b0}, // R8 fault at index 0
    '{32'h0000_1000, 1'b0, 2'd0, 2'd0, 2'd0, 1'b1}  // R8 buffer unchanged
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          flush = 1'b0;
  logic          fetchValid = 1'b0;
  logic [AW-1:0] fetchAddr = '0;
  logic          compEn = 1'b0;
  logic          busy, rspValid, xlReq, memReq, memHalf;
  logic [31:0]   rspInsn;
  logic [1:0]    rspCause;
  logic [AW-1:0] xlVaddr, memAddr;
  logic          xlAck = 1'b0, xlFault = 1'b0, memAck = 1'b0;
  logic [AW-1:0] xlPaddr = '0;
  logic [31:0]   memData = '0;

  int checks = 0, fails = 0;
  int xlCount = 0, memCount = 0, rspCount = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  cfetch_unit #(.AW(AW), .ENTRIES(32)) dut_i (
    .clk(clk), .rstN(rstN), .flush(flush), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .compEn(compEn), .busy(busy), .rspValid(rspValid),
    .rspInsn(rspInsn), .rspCause(rspCause), .xlReq(xlReq), .xlVaddr(xlVaddr),
    .xlAck(xlAck), .xlFault(xlFault), .xlPaddr(xlPaddr), .memReq(memReq),
    .memAddr(memAddr), .memHalf(memHalf), .memAck(memAck), .memData(memData)
  );

  function automatic logic [31:0] xlMap(input logic [31:0] v);
    return v ^ 32'h0001_0000;
  endfunction

  function automatic logic [15:0] hw(input logic [31:0] a);
    return {a[17:4] ^ 14'h1A5B, a[5:4]};
  endfunction

  function automatic logic [31:0] expInsn(input logic [31:0] v);
    logic [15:0] lo;
    if (!v[1]) return {hw(xlMap(v) + 32'd2), hw(xlMap(v))};
    lo = hw(xlMap(v));
    if (lo[1:0] != 2'b11) return {16'h0000, lo};
    return {hw(xlMap(v + 32'd2)), lo};
  endfunction

  // Translation responder
  initial forever begin
    @(negedge clk);
    if (xlReq && !xlAck) begin
      xlAck   = 1'b1;
      xlPaddr = xlMap(xlVaddr);
      xlFault = (xlVaddr[31:28] == 4'hF);
      xlCount++;
    end else begin
      xlAck = 1'b0;
    end
  end

  // Memory responder
  initial forever begin
    @(negedge clk);
    if (memReq && !memAck) begin
      memAck  = 1'b1;
      memData = memHalf ? {16'h0000, hw(memAddr)} : {hw(memAddr + 32'd2), hw(memAddr)};
      memCount++;
    end else begin
      memAck = 1'b0;
    end
  end

  initial forever begin
    @(posedge clk);
    #1;
    if (rspValid) rspCount++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doFetch(input logic [31:0] a, input logic c,
                         output logic [31:0] insn, output logic [1:0] cause,
                         output int nXl, output int nMem, output int lat);
    int x0, m0;
    @(negedge clk);
    x0 = xlCount; m0 = memCount;
    fetchValid = 1'b1; fetchAddr = a; compEn = c;
    @(negedge clk);
    fetchValid = 1'b0;
    lat = 1;
    while (!rspValid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    insn = rspInsn; cause = rspCause;
    nXl = xlCount - x0; nMem = memCount - m0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] insn, eIns;
    logic [1:0]  cause;
    int nXl, nMem, lat, r0;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !rspValid && !xlReq && !memReq, "R1 reset outputs",
          {28'h0, busy, rspValid, xlReq, memReq}, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      doFetch(VEC[i].addr, VEC[i].comp, insn, cause, nXl, nMem, lat);
      eIns = (VEC[i].cause == 2'd0) ? expInsn(VEC[i].addr) : 32'h0;
      check(insn == eIns, $sformatf("R2/R5/R6 vec %0d insn", i), insn, eIns);
      check(cause == VEC[i].cause, $sformatf("R7/R8 vec %0d cause", i),
            {30'h0, cause}, {30'h0, VEC[i].cause});
      check(nXl == VEC[i].nXl && nMem == VEC[i].nMem,
            $sformatf("R3/R4/R9 vec %0d requests xl/mem", i),
            {nXl[15:0], nMem[15:0]}, {14'h0, VEC[i].nXl, 14'h0, VEC[i].nMem});
      if (VEC[i].fast)
        check(lat == 1, $sformatf("R3 vec %0d latency", i), lat, 1);
      @(negedge clk);
      check(!rspValid, $sformatf("R12 vec %0d single pulse", i), {31'h0, rspValid}, 0);
    end

    // R10 flush invalidates a resident entry
    doFetch(32'h0000_1000, 1'b0, insn, cause, nXl, nMem, lat);
    check(nXl == 0, "R10 resident before flush", nXl, 0);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    doFetch(32'h0000_1000, 1'b0, insn, cause, nXl, nMem, lat);
    check(nXl == 1 && nMem == 1, "R10 miss after flush", {nXl[15:0], nMem[15:0]}, 32'h0001_0001);
    check(insn == expInsn(32'h0000_1000), "R10 refill data", insn, expInsn(32'h0000_1000));

    // R11 request while busy is ignored
    @(negedge clk);
    r0 = rspCount;
    fetchValid = 1'b1; fetchAddr = 32'h0000_4000; compEn = 1'b0;
    @(negedge clk);
    fetchAddr = 32'h0000_5001; compEn = 1'b1;
    check(busy, "R11 busy during miss", {31'h0, busy}, 1);
    @(negedge clk);
    fetchValid = 1'b0;
    repeat (12) @(negedge clk);
    check(rspCount - r0 == 1, "R11 one response only", rspCount - r0, 1);
    check(rspInsn == expInsn(32'h0000_4000) && rspCause == 2'd0, "R11 first fetch result",
          rspInsn, expInsn(32'h0000_4000));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule